// File: doc/BRIEF.md
# Transmit Phase-Align Buffer

This block carries 10-bit transmit characters from the clock that captures them into the internal character clock. The two clocks run at the same rate, but their relative phase is unknown and may wander slowly. When the capture clock is the reference clock itself, the bypass select routes the captured character straight to the output. This avoids the buffer latency. In every other case the characters pass through a small dual-clock FIFO whose pointer spacing is set when reset is released.

After alignment the read side watches how far the pointer spacing, as seen through the synchronizers, has moved from its aligned value. Wander of less than one character in either direction does nothing. Wander of two characters raises a sticky error flag, and from then on the output carries a fixed error-indication character in place of data. The error clears either when a new reset arrives or when a re-center request arrives, which is what a word-sync sequence on the input side produces. A re-center re-aligns the pointers without a full reset. While the pointers re-align, a few idle characters take the place of data, so some characters may be lost or repeated at that moment.

Top module: `tx_phase_align`

## Requirements
- R1: Reset takes effect only when `rst_n` is sampled low on two consecutive rising edges of `wr_clk`. A low level seen on just one edge leaves the character stream uninterrupted.
- R2: While reset is active, and while the pointers align after it, `err_o` is 0 and `char_o` carries IDLE_CHAR (default 10'h0FA).
- R3: In buffered mode (`bypass_i` = 0) each character written with `tx_valid_i` = 1 appears on `char_o` exactly once and in write order. One character is read per `rd_clk` cycle.
- R4: A phase drift between the two clocks of less than half a character period in either direction never raises `err_o` and never breaks the order of the stream.
- R5: When the synchronized pointer spacing moves DRIFT_LIM (default 2) characters or more away from its aligned value, `err_o` goes to 1.
- R6: Once raised, `err_o` stays 1 until the next reset or re-center. This holds even if the phase drifts back, and it holds across a period spent in bypass.
- R7: While the error is held, `char_o` carries ERR_CHAR (default 10'h2B8) on every `rd_clk` cycle.
- R8: A re-center request (`recenter_i` held high for at least three `rd_clk` cycles) made while the error is held clears `err_o`, re-aligns the pointers and resumes an ordered stream.
- R9: A re-center request made while no error is held is ignored, and the stream continues with no idle gap.
- R10: A cycle of `wr_clk` with `tx_valid_i` = 0 writes nothing and counts as drift, so a run of four or more missing characters raises `err_o`.
- R11: With `bypass_i` = 1, `char_o` equals the character presented at the previous rising edge of `wr_clk`, and `err_o` is 0.
- R12: A reset clears a held error, and the ordered stream resumes after alignment.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| wr_clk | input | 1 | Input (capture) clock |
| rd_clk | input | 1 | Internal character clock |
| rst_n | input | 1 | Active-low reset, sampled on wr_clk |
| bypass_i | input | 1 | 1: input is synchronous to the reference, skip the buffer |
| tx_valid_i | input | 1 | Character strobe on the write side |
| tx_char_i | input | CW (10) | Character to transmit |
| recenter_i | input | 1 | Re-center request (word-sync), wr_clk side level |
| char_o | output | CW (10) | Character in the character-clock domain |
| err_o | output | 1 | Sticky phase-tolerance error |

## Verification
The bench builds the block with DEPTH = 8, DRIFT_LIM = 2 and SETTLE = 4. With those values a ramp of 9 ns in each direction on a 20 ns character stays inside the window. A ramp of 60 ns crosses the limit within a few hundred cycles, and a gap of four missing characters also crosses it. The SETTLE value makes the idle gap caused by a re-align long enough that the order monitor sees it whenever a re-align happens when it should not. The bench also runs an error period through bypass and back, to show that the flag survives the switch.

// File: rtl/pab_pkg.sv
`timescale 1ns/10ps
package pab_pkg;
  // Read-side control state
  typedef enum logic {
    ST_ALIGN = 1'b0,
    ST_RUN   = 1'b1
  } rd_state_e;
endpackage

// File: rtl/pab_sync.sv
`timescale 1ns/10ps
// Multi-stage synchronizer bank; bit vectors must be Gray-coded or single-bit.
module pab_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg_q [STAGES];

  always_ff @(posedge clk) begin
    stg_q[0] <= d;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk) begin
      stg_q[s] <= stg_q[s-1];
    end
  end

  assign q = stg_q[STAGES-1];
endmodule

// File: rtl/pab_wr_side.sv
`timescale 1ns/10ps
// Write domain: bypass register, FIFO storage, Gray write pointer.
module pab_wr_side #(
  parameter int CW    = 10,
  parameter int DEPTH = 8,
  parameter int AW    = 3,
  parameter int PW    = 4
) (
  input  logic          wr_clk,
  input  logic          wr_init,
  input  logic          wr_valid,
  input  logic [CW-1:0] wr_char,
  input  logic [AW-1:0] rd_idx,
  output logic [CW-1:0] in_q,
  output logic [PW-1:0] wr_gray_q,
  output logic [CW-1:0] rd_word
);
  logic [PW-1:0] wr_bin_q, wr_bin_d;
  logic [PW-1:0] wr_gray_d;
  logic [CW-1:0] mem_q [DEPTH];
  logic          mem_we;

  // next-state
  always_comb begin
    wr_bin_d = wr_bin_q;
    if (wr_valid) begin
      wr_bin_d = wr_bin_q + PW'(1);
    end
    wr_gray_d = wr_bin_d ^ (wr_bin_d >> 1);
    mem_we    = wr_valid && !wr_init;
  end

  // pointer registers
  always_ff @(posedge wr_clk) begin
    if (wr_init) begin
      wr_bin_q  <= '0;
      wr_gray_q <= '0;
    end else begin
      wr_bin_q  <= wr_bin_d;
      wr_gray_q <= wr_gray_d;
    end
  end

  // bypass capture register, loaded every cycle
  always_ff @(posedge wr_clk) begin
    if (wr_init) begin
      in_q <= '0;
    end else begin
      in_q <= wr_char;
    end
  end

  // storage with explicit write enable
  always_ff @(posedge wr_clk) begin
    if (mem_we) begin
      mem_q[wr_bin_q[AW-1:0]] <= wr_char;
    end
  end

  assign rd_word = mem_q[rd_idx];

  // R3: an idle write cycle leaves the published pointer untouched
  p_gray_hold_r3: assert property (@(posedge wr_clk) disable iff (wr_init)
    !wr_valid |=> $stable(wr_gray_q));

  // R3: a write moves the Gray pointer by exactly one bit
  p_gray_step_r3: assert property (@(posedge wr_clk) disable iff (wr_init)
    wr_valid |=> ($countones(wr_gray_q ^ $past(wr_gray_q)) == 1));
endmodule

// File: rtl/pab_rd_side.sv
`timescale 1ns/10ps
// Read domain: alignment, drift monitor, sticky error, output register.
module pab_rd_side
  import pab_pkg::*;
#(
  parameter int          CW        = 10,
  parameter int          AW        = 3,
  parameter int          PW        = 4,
  parameter int          ALIGN     = 2,
  parameter int          DRIFT_LIM = 2,
  parameter int          SETTLE    = 4,
  parameter logic [9:0]  IDLE_CHAR = 10'h0FA,
  parameter logic [9:0]  ERR_CHAR  = 10'h2B8
) (
  input  logic          rd_clk,
  input  logic          rd_init,
  input  logic [PW-1:0] wr_gray_s,
  input  logic          recenter_s,
  input  logic [CW-1:0] rd_word,
  output logic [AW-1:0] rd_idx,
  output logic [CW-1:0] out_q,
  output logic          err_q
);
  localparam int CNTW = $clog2(SETTLE + 1);
  localparam logic signed [PW-1:0] LIM_S = PW'(DRIFT_LIM);

  rd_state_e       st_q, st_d;
  logic [PW-1:0]   rd_ptr_q, rd_ptr_d;
  logic [CNTW-1:0] cnt_q, cnt_d;
  logic            err_d;
  logic [CW-1:0]   out_d;
  logic            rc_prev_q;
  logic            rc_rise;
  logic [PW-1:0]   wr_bin_s;
  logic [PW-1:0]   spacing;
  logic signed [PW-1:0] dev_s;
  logic            drift_hit;

  // Gray to binary
  always_comb begin
    wr_bin_s[PW-1] = wr_gray_s[PW-1];
    for (int i = PW - 2; i >= 0; i--) begin
      wr_bin_s[i] = wr_bin_s[i+1] ^ wr_gray_s[i];
    end
  end

  assign spacing   = wr_bin_s - rd_ptr_q - PW'(ALIGN);
  assign dev_s     = signed'(spacing);
  assign drift_hit = (dev_s >= LIM_S) || (dev_s <= -LIM_S);
  assign rc_rise   = recenter_s && !rc_prev_q;
  assign rd_idx    = rd_ptr_q[AW-1:0];

  // next-state
  always_comb begin
    st_d     = st_q;
    rd_ptr_d = rd_ptr_q;
    cnt_d    = cnt_q;
    err_d    = err_q;
    out_d    = out_q;
    case (st_q)
      ST_ALIGN: begin
        rd_ptr_d = wr_bin_s - PW'(ALIGN) + PW'(1);
        out_d    = IDLE_CHAR;
        err_d    = 1'b0;
        if (cnt_q == CNTW'(SETTLE - 1)) begin
          st_d  = ST_RUN;
          cnt_d = '0;
        end else begin
          cnt_d = cnt_q + CNTW'(1);
        end
      end
      default: begin
        rd_ptr_d = rd_ptr_q + PW'(1);
        if (err_q) begin
          out_d = ERR_CHAR;
          if (rc_rise) begin
            st_d  = ST_ALIGN;
            err_d = 1'b0;
            cnt_d = '0;
          end
        end else if (drift_hit) begin
          err_d = 1'b1;
          out_d = ERR_CHAR;
        end else begin
          out_d = rd_word;
        end
      end
    endcase
  end

  // registers
  always_ff @(posedge rd_clk) begin
    if (rd_init) begin
      st_q      <= ST_ALIGN;
      rd_ptr_q  <= '0;
      cnt_q     <= '0;
      err_q     <= 1'b0;
      out_q     <= IDLE_CHAR;
      rc_prev_q <= 1'b0;
    end else begin
      st_q      <= st_d;
      rd_ptr_q  <= rd_ptr_d;
      cnt_q     <= cnt_d;
      err_q     <= err_d;
      out_q     <= out_d;
      rc_prev_q <= recenter_s;
    end
  end

  // R6: a held error persists unless a re-center arrives
  p_err_sticky_r6: assert property (@(posedge rd_clk) disable iff (rd_init)
    (err_q && !rc_rise) |=> err_q);

  // R7: an error cycle is followed by the error character
  p_err_char_r7: assert property (@(posedge rd_clk) disable iff (rd_init)
    err_q |=> (out_q == ERR_CHAR));

  // R2: alignment phase emits idle characters
  p_idle_align_r2: assert property (@(posedge rd_clk) disable iff (rd_init)
    (st_q == ST_ALIGN) |=> (out_q == IDLE_CHAR));

  // R8: no error can be held while aligning
  p_align_clear_r8: assert property (@(posedge rd_clk) disable iff (rd_init)
    (st_q == ST_ALIGN) |-> !err_q);

  // R9: a running, error-free buffer never drops back to alignment
  p_no_realign_r9: assert property (@(posedge rd_clk) disable iff (rd_init)
    (st_q == ST_RUN && !err_q) |=> (st_q == ST_RUN));
endmodule

// File: rtl/tx_phase_align.sv
`timescale 1ns/10ps
module tx_phase_align #(
  parameter int         CW        = 10,
  parameter int         DEPTH     = 8,
  parameter int         DRIFT_LIM = 2,
  parameter int         SETTLE    = 4,
  parameter logic [9:0] IDLE_CHAR = 10'h0FA,
  parameter logic [9:0] ERR_CHAR  = 10'h2B8
) (
  input  logic          wr_clk,
  input  logic          rd_clk,
  input  logic          rst_n,
  input  logic          bypass_i,
  input  logic          tx_valid_i,
  input  logic [CW-1:0] tx_char_i,
  input  logic          recenter_i,
  output logic [CW-1:0] char_o,
  output logic          err_o
);
  localparam int AW    = $clog2(DEPTH);
  localparam int PW    = AW + 1;
  localparam int SYNC  = 2;
  localparam int ALIGN = DEPTH / 2 - SYNC;

  logic [1:0]    rst_smp_q;
  logic          wr_init;
  logic          rd_init;
  logic [PW-1:0] wr_gray_q, wr_gray_s;
  logic          recenter_s;
  logic [AW-1:0] rd_idx;
  logic [CW-1:0] rd_word, in_q, out_q;
  logic          err_q;

  // reset pin sampled on two consecutive wr_clk edges
  always_ff @(posedge wr_clk) begin
    rst_smp_q <= {rst_smp_q[0], rst_n};
  end
  assign wr_init = ~|rst_smp_q;

  pab_sync #(.W(1), .STAGES(SYNC)) u_rst_sync (
    .clk (rd_clk),
    .d   (wr_init),
    .q   (rd_init)
  );

  pab_sync #(.W(PW), .STAGES(SYNC)) u_ptr_sync (
    .clk (rd_clk),
    .d   (wr_gray_q),
    .q   (wr_gray_s)
  );

  pab_sync #(.W(1), .STAGES(SYNC)) u_rc_sync (
    .clk (rd_clk),
    .d   (recenter_i),
    .q   (recenter_s)
  );

  pab_wr_side #(.CW(CW), .DEPTH(DEPTH), .AW(AW), .PW(PW)) u_wr (
    .wr_clk    (wr_clk),
    .wr_init   (wr_init),
    .wr_valid  (tx_valid_i),
    .wr_char   (tx_char_i),
    .rd_idx    (rd_idx),
    .in_q      (in_q),
    .wr_gray_q (wr_gray_q),
    .rd_word   (rd_word)
  );

  pab_rd_side #(
    .CW(CW), .AW(AW), .PW(PW), .ALIGN(ALIGN), .DRIFT_LIM(DRIFT_LIM),
    .SETTLE(SETTLE), .IDLE_CHAR(IDLE_CHAR), .ERR_CHAR(ERR_CHAR)
  ) u_rd (
    .rd_clk     (rd_clk),
    .rd_init    (rd_init),
    .wr_gray_s  (wr_gray_s),
    .recenter_s (recenter_s),
    .rd_word    (rd_word),
    .rd_idx     (rd_idx),
    .out_q      (out_q),
    .err_q      (err_q)
  );

  assign char_o = bypass_i ? in_q : out_q;
  assign err_o  = err_q & ~bypass_i;
endmodule

// File: tb/tx_phase_align_tb.sv
`timescale 1ns/10ps
module tx_phase_align_tb;
  localparam logic [9:0] IDLE = 10'h0FA;
  localparam logic [9:0] ERRC = 10'h2B8;

  logic       wr_clk = 0, rd_clk = 0, rst_n = 0;
  logic       bypass = 0, valid = 0, recenter = 0;
  logic [9:0] tx_char = '0;
  logic [9:0] char_o;
  logic       err_o;

  real hp = 10.0;
  int  n_chk = 0, n_fail = 0;
  bit  gen_on = 0, mon_on = 0, mon_first = 1, done = 0;
  int  brk = 0, errs = 0;
  logic [9:0] mon_prev = '0;

  tx_phase_align #(.CW(10), .DEPTH(8), .DRIFT_LIM(2), .SETTLE(4),
                   .IDLE_CHAR(IDLE), .ERR_CHAR(ERRC)) u_dut (
    .wr_clk(wr_clk), .rd_clk(rd_clk), .rst_n(rst_n), .bypass_i(bypass),
    .tx_valid_i(valid), .tx_char_i(tx_char), .recenter_i(recenter),
    .char_o(char_o), .err_o(err_o)
  );

  initial forever #10 wr_clk = ~wr_clk;            // 50 MHz
  initial begin #7; forever begin #(hp) rd_clk = ~rd_clk; end end

  // write-side stimulus, changed away from the capture edge
  initial forever begin
    @(negedge wr_clk);
    if (gen_on) begin valid = 1; tx_char = tx_char + 10'd1; end
    else valid = 0;
  end

  // order monitor on the character clock
  initial forever begin
    @(negedge rd_clk);
    if (mon_on) begin
      if (err_o) errs++;
      if (!mon_first && char_o != 10'(mon_prev + 10'd1)) brk++;
      mon_first = 0;
      mon_prev  = char_o;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic report();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  task automatic mon_start();
    brk = 0; errs = 0; mon_first = 1; mon_on = 1;
  endtask

  task automatic mon_stop(input string req);
    mon_on = 0;
    chk(brk == 0, req, brk, 0);
    chk(errs == 0, req, errs, 0);
  endtask

  task automatic ramp(input real h, input int n);
    hp = h;
    repeat (n) @(posedge rd_clk);
    hp = 10.0;
  endtask

  task automatic t_reset_state();
    rst_n = 0; gen_on = 1;
    repeat (6) @(negedge rd_clk);
    chk(err_o == 0, "R2", err_o, 0);
    chk(char_o == IDLE, "R2", char_o, IDLE);
    @(negedge wr_clk) rst_n = 1;
    @(negedge rd_clk);
    chk(char_o == IDLE, "R2", char_o, IDLE);
    repeat (30) @(negedge rd_clk);
    mon_start();
    repeat (200) @(negedge rd_clk);
    mon_stop("R3");
  endtask

  task automatic t_glitch();
    mon_start();
    repeat (10) @(negedge rd_clk);
    @(negedge wr_clk) rst_n = 0;
    @(negedge wr_clk) rst_n = 1;
    repeat (60) @(negedge rd_clk);
    mon_stop("R1");
  endtask

  task automatic t_small_drift();
    mon_start();
    ramp(10.05, 90);
    ramp(9.95, 180);
    ramp(10.05, 90);
    repeat (20) @(negedge rd_clk);
    mon_stop("R4");
  endtask

  task automatic t_recenter_idle();
    mon_start();
    @(negedge wr_clk) recenter = 1;
    repeat (5) @(negedge wr_clk);
    recenter = 0;
    repeat (50) @(negedge rd_clk);
    mon_stop("R9");
  endtask

  task automatic t_big_drift();
    ramp(10.05, 600);
    repeat (5) @(negedge rd_clk);
    chk(err_o == 1, "R5", err_o, 1);
    chk(char_o == ERRC, "R7", char_o, ERRC);
    ramp(9.95, 600);
    repeat (5) @(negedge rd_clk);
    chk(err_o == 1, "R6", err_o, 1);
    chk(char_o == ERRC, "R7", char_o, ERRC);
  endtask

  task automatic t_bypass();
    bypass = 1;
    repeat (3) @(posedge wr_clk);
    #5;
    chk(char_o == tx_char, "R11", char_o, tx_char);
    chk(err_o == 0, "R11", err_o, 0);
    repeat (2) @(posedge wr_clk);
    #5;
    chk(char_o == tx_char, "R11", char_o, tx_char);
    chk(err_o == 0, "R11", err_o, 0);
    bypass = 0;
    repeat (3) @(negedge rd_clk);
    chk(err_o == 1, "R6", err_o, 1);
  endtask

  task automatic t_recenter();
    @(negedge wr_clk) recenter = 1;
    repeat (5) @(negedge wr_clk);
    recenter = 0;
    repeat (20) @(negedge rd_clk);
    chk(err_o == 0, "R8", err_o, 0);
    mon_start();
    repeat (100) @(negedge rd_clk);
    mon_stop("R8");
  endtask

  task automatic t_gap();
    @(negedge wr_clk) gen_on = 0;
    repeat (4) @(negedge wr_clk);
    gen_on = 1;
    repeat (12) @(negedge rd_clk);
    chk(err_o == 1, "R10", err_o, 1);
    chk(char_o == ERRC, "R10", char_o, ERRC);
  endtask

  task automatic t_reset_clear();
    @(negedge wr_clk) rst_n = 0;
    repeat (4) @(negedge wr_clk);
    rst_n = 1;
    repeat (30) @(negedge rd_clk);
    chk(err_o == 0, "R12", err_o, 0);
    mon_start();
    repeat (100) @(negedge rd_clk);
    mon_stop("R12");
  endtask

  initial begin
    #2_000_000;
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    report();
  end

  initial begin
    t_reset_state();
    t_glitch();
    t_small_drift();
    t_recenter_idle();
    t_big_drift();
    t_bypass();
    t_recenter();
    t_gap();
    t_reset_clear();
    report();
  end
endmodule